// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block drains received packet data from an on-chip receive FIFO and places it in host memory. Placement is governed by descriptors that live in host memory. Each descriptor is four consecutive 32-bit words. The engine reads a descriptor over a single-beat memory master port and checks that the host has handed it over. It takes up to two buffer regions from the descriptor and writes the packet into them one 32-bit word at a time. When a descriptor is finished, the engine writes a status word back over its first word, which also returns ownership to the host.

Descriptors can be laid out as a contiguous ring, linked as a chain, or mixed, and the choice is made per descriptor. A packet larger than one descriptor's buffers continues in the next descriptor. If no owned descriptor is available partway through a packet, the rest of the packet is discarded and the damage is reported in the status. Software provides a base address for the list and pulses a poll strobe whenever it has handed descriptors to the engine.

Top module: `rx_desc_dma`

## Requirements
- R1: When word 0 bit 31 (ownership) of the descriptor being examined is 0, the engine stops after that single read, keeps `fifo_ready` low and issues no memory access until `poll` is pulsed. The first `poll` after reset starts the engine at `desc_base`.
- R2: In ring layout the next descriptor sits 16 bytes after the current one. When word 1 bit 25 (end-of-ring) is set, the next descriptor is `desc_base`, and this takes priority over chain mode.
- R3: When word 1 bit 24 (chain) is set, word 3 is the address of the next descriptor and the second buffer is never written. Ring and chain descriptors may be mixed in one list.
- R4: Word 1 bits 10:0 give the first buffer size and bits 21:11 the second, both in bytes with the low two bits ignored. Data fills the first buffer, starting at the word 2 address, before the second buffer, starting at the word 3 address. No word is written past a buffer's size.
- R5: A buffer of size zero is skipped and receives no write.
- R6: A packet that overflows one descriptor continues in the next. In the status written back, bit 9 (first descriptor) is set only for the packet's first descriptor and bit 8 (last descriptor) only for its final one.
- R7: The status written to word 0 always has bit 31 clear. On the final descriptor of a packet it carries the total packet length in bytes in bits 26:16 and `rx_stat` in bits 7:0. On other descriptors those fields are zero.
- R8: If the next descriptor is not owned partway through a packet, the engine discards the rest of that packet from the FIFO. It then writes the last used descriptor's status with bits 8, 9 (if it was first) and 11 (overflow) set and the full packet length, and waits for `poll` at the unowned descriptor.
- R9: Each memory access is one beat. `mem_req` and its address, direction and data stay stable until `mem_ack`, only one access is outstanding at a time, and a descriptor costs four reads and one status write.
- R10: While `rst` is high and in the cycle after it, `mem_req` and `fifo_ready` are low.
- R11: A FIFO word is popped when `fifo_valid` and `fifo_ready` are both high. On the word with `fifo_last` set, `fifo_nbytes` = k means k+1 valid bytes; every other word counts 4 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_base | input | AW | Byte address of the first descriptor in the list |
| poll | input | 1 | One-cycle strobe: re-examine the current descriptor |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_ready | output | 1 | Engine takes the FIFO word this cycle |
| fifo_data | input | 32 | Packet data word, first byte in bits 7:0 |
| fifo_last | input | 1 | This word ends the packet |
| fifo_nbytes | input | 2 | Valid bytes minus one in the final word |
| rx_stat | input | STW | Receive status, sampled with the final word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Two functions can meet at a descriptor boundary. Releasing a full descriptor and claiming the next one happen together, because the engine fetches the successor before it writes back the descriptor it is leaving. The overflow scenario provokes this: a two-word buffer receives a five-word packet while the following descriptor is still owned by the host. That run is judged by the written-back status, which must show first, last and overflow flags with the complete 17-byte length. It also requires the tail buffer word to stay untouched, the FIFO to be drained, and the unowned descriptor to be left unmodified. The chained multi-descriptor run covers the successful side of the same boundary.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DW       = 32;
  localparam int SZW      = 11;
  localparam int LENW     = 11;
  localparam int OWN_BIT  = 31;
  localparam int EOR_BIT  = 25;
  localparam int CHN_BIT  = 24;
  localparam int B1_LO    = 0;
  localparam int B2_LO    = 11;
  localparam int LEN_LO   = 16;
  localparam int OVF_BIT  = 11;
  localparam int FS_BIT   = 9;
  localparam int LS_BIT   = 8;

  typedef enum logic [3:0] {
    S_WAITP,
    S_FETCH,
    S_WBPREV,
    S_SEL,
    S_DATA,
    S_WR,
    S_WBLAST,
    S_FLUSH,
    S_WBOVF
  } rxd_st_t;
endpackage

// File: rtl/rxd_mem_port.sv
module rxd_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (go) begin
      mem_req   <= 1'b1;
      mem_we    <= we_i;
      mem_addr  <= addr_i;
      mem_wdata <= wdata_i;
    end else if (mem_ack) begin
      mem_req   <= 1'b0;
    end
  end

  assign done = mem_req & mem_ack;
endmodule

// File: rtl/rxd_next_ptr.sv
module rxd_next_ptr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic          ring_end,
  input  logic          chain,
  input  logic [AW-1:0] link,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP = AW'(16);

  always_comb begin
    if (ring_end)   nxt = base;
    else if (chain) nxt = link;
    else            nxt = cur + STEP;
  end
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
  import rxd_pkg::*;
#(
  parameter int STW = 8
) (
  input  logic            fs,
  input  logic            ls,
  input  logic            ovf,
  input  logic [LENW-1:0] len,
  input  logic [STW-1:0]  rxs,
  output logic [DW-1:0]   word
);
  always_comb begin
    word          = '0;
    word[FS_BIT]  = fs;
    word[LS_BIT]  = ls;
    word[OVF_BIT] = ovf;
    if (ls) begin
      word[LEN_LO +: LENW] = len;
      word[STW-1:0]        = rxs;
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int STW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  desc_base,
  input  logic           poll,
  input  logic           fifo_valid,
  output logic           fifo_ready,
  input  logic [DW-1:0]  fifo_data,
  input  logic           fifo_last,
  input  logic [1:0]     fifo_nbytes,
  input  logic [STW-1:0] rx_stat,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int WCW = SZW - 2;
  localparam logic [AW-1:0] WSTEP = AW'(4);

  rxd_st_t         st;
  logic [1:0]      widx;
  logic [AW-1:0]   cur_addr, prev_addr, wptr;
  logic            base_ok;
  logic [WCW-1:0]  b1w, b2w, rem;
  logic            chain_m, eor_m;
  logic [AW-1:0]   w2, w3;
  logic [1:0]      bsel;
  logic            first, prev_first, pend, hlast;
  logic [LENW-1:0] len;
  logic [STW-1:0]  rxs_q;

  logic            go, cmd_we, done;
  logic [AW-1:0]   cmd_addr;
  logic [DW-1:0]   cmd_wdata;
  logic [AW-1:0]   nxt;
  logic [DW-1:0]   stat_word;
  logic            fs_s, ls_s, ovf_s;
  logic [LENW-1:0] len_s, len_nx;
  logic [STW-1:0]  rxs_s;
  logic [2:0]      add_b;

  assign fifo_ready = (st == S_DATA) || (st == S_FLUSH);
  assign add_b  = fifo_last ? ({1'b0, fifo_nbytes} + 3'd1) : 3'd4;
  assign len_nx = len + LENW'(add_b);

  rxd_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .go(go), .we_i(cmd_we), .addr_i(cmd_addr),
    .wdata_i(cmd_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .done(done)
  );

  rxd_next_ptr #(.AW(AW)) u_next (
    .cur(cur_addr), .base(desc_base), .ring_end(eor_m), .chain(chain_m),
    .link(w3), .nxt(nxt)
  );

  always_comb begin
    fs_s  = prev_first;
    ls_s  = 1'b0;
    ovf_s = 1'b0;
    len_s = '0;
    rxs_s = '0;
    if (st == S_FLUSH) begin
      ls_s  = 1'b1;
      ovf_s = 1'b1;
      len_s = len_nx;
      rxs_s = rx_stat;
    end else if (st == S_WR) begin
      fs_s  = first;
      ls_s  = 1'b1;
      len_s = len;
      rxs_s = rxs_q;
    end
  end

  rxd_status_fmt #(.STW(STW)) u_fmt (
    .fs(fs_s), .ls(ls_s), .ovf(ovf_s), .len(len_s), .rxs(rxs_s),
    .word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_WAITP;
      widx       <= '0;
      cur_addr   <= '0;
      prev_addr  <= '0;
      wptr       <= '0;
      base_ok    <= 1'b0;
      b1w        <= '0;
      b2w        <= '0;
      rem        <= '0;
      chain_m    <= 1'b0;
      eor_m      <= 1'b0;
      w2         <= '0;
      w3         <= '0;
      bsel       <= '0;
      first      <= 1'b1;
      prev_first <= 1'b0;
      pend       <= 1'b0;
      hlast      <= 1'b0;
      len        <= '0;
      rxs_q      <= '0;
      go         <= 1'b0;
      cmd_we     <= 1'b0;
      cmd_addr   <= '0;
      cmd_wdata  <= '0;
    end else begin
      go <= 1'b0;
      unique case (st)
        S_WAITP: begin
          if (poll) begin
            widx   <= '0;
            go     <= 1'b1;
            cmd_we <= 1'b0;
            if (!base_ok) begin
              base_ok  <= 1'b1;
              cur_addr <= desc_base;
              cmd_addr <= desc_base;
            end else begin
              cmd_addr <= cur_addr;
            end
            st <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (done) begin
            if (widx == 2'd0 && !mem_rdata[OWN_BIT]) begin
              st <= pend ? S_FLUSH : S_WAITP;
            end else if (widx == 2'd3) begin
              w3   <= mem_rdata[AW-1:0];
              bsel <= 2'd0;
              if (pend) begin
                go        <= 1'b1;
                cmd_we    <= 1'b1;
                cmd_addr  <= prev_addr;
                cmd_wdata <= stat_word;
                st        <= S_WBPREV;
              end else begin
                st <= S_SEL;
              end
            end else begin
              if (widx == 2'd1) begin
                b1w     <= mem_rdata[B1_LO+2 +: WCW];
                b2w     <= mem_rdata[B2_LO+2 +: WCW];
                chain_m <= mem_rdata[CHN_BIT];
                eor_m   <= mem_rdata[EOR_BIT];
              end else if (widx == 2'd2) begin
                w2 <= mem_rdata[AW-1:0];
              end
              widx     <= widx + 2'd1;
              go       <= 1'b1;
              cmd_we   <= 1'b0;
              cmd_addr <= cur_addr + AW'({widx + 2'd1, 2'b00});
            end
          end
        end
        S_WBPREV: begin
          if (done) begin
            pend <= 1'b0;
            st   <= S_SEL;
          end
        end
        S_SEL: begin
          if (bsel == 2'd0) begin
            bsel <= 2'd1;
            if (b1w != '0) begin
              wptr <= w2;
              rem  <= b1w;
              st   <= S_DATA;
            end
          end else if (bsel == 2'd1) begin
            bsel <= 2'd2;
            if (b2w != '0 && !chain_m) begin
              wptr <= w3;
              rem  <= b2w;
              st   <= S_DATA;
            end
          end else begin
            prev_addr  <= cur_addr;
            prev_first <= first;
            first      <= 1'b0;
            pend       <= 1'b1;
            cur_addr   <= nxt;
            widx       <= '0;
            go         <= 1'b1;
            cmd_we     <= 1'b0;
            cmd_addr   <= nxt;
            st         <= S_FETCH;
          end
        end
        S_DATA: begin
          if (fifo_valid) begin
            hlast     <= fifo_last;
            len       <= len_nx;
            if (fifo_last) rxs_q <= rx_stat;
            go        <= 1'b1;
            cmd_we    <= 1'b1;
            cmd_addr  <= wptr;
            cmd_wdata <= fifo_data;
            st        <= S_WR;
          end
        end
        S_WR: begin
          if (done) begin
            wptr <= wptr + WSTEP;
            rem  <= rem - WCW'(1);
            if (hlast) begin
              go        <= 1'b1;
              cmd_we    <= 1'b1;
              cmd_addr  <= cur_addr;
              cmd_wdata <= stat_word;
              st        <= S_WBLAST;
            end else if (rem == WCW'(1)) begin
              st <= S_SEL;
            end else begin
              st <= S_DATA;
            end
          end
        end
        S_WBLAST: begin
          if (done) begin
            cur_addr <= nxt;
            first    <= 1'b1;
            len      <= '0;
            widx     <= '0;
            go       <= 1'b1;
            cmd_we   <= 1'b0;
            cmd_addr <= nxt;
            st       <= S_FETCH;
          end
        end
        S_FLUSH: begin
          if (fifo_valid) begin
            len <= len_nx;
            if (fifo_last) begin
              go        <= 1'b1;
              cmd_we    <= 1'b1;
              cmd_addr  <= prev_addr;
              cmd_wdata <= stat_word;
              st        <= S_WBOVF;
            end
          end
        end
        S_WBOVF: begin
          if (done) begin
            len   <= '0;
            first <= 1'b1;
            pend  <= 1'b0;
            st    <= S_WAITP;
          end
        end
        default: st <= S_WAITP;
      endcase
    end
  end
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          fifo_ready
);
  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !fifo_ready));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R9
  ack_pair_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> mem_req);

  // R11
  pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_ready && mem_req));
endmodule

bind rx_desc_dma rxd_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .fifo_ready(fifo_ready)
);

// File: tb/sim_rx_desc_dma.sv
`timescale 1ns/1ps
module sim_rx_desc_dma;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] SENT = 32'h5A5A5A5A;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] FS   = 32'h200;
  localparam logic [31:0] LS   = 32'h100;
  localparam logic [31:0] OVF  = 32'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic poll = 1'b0;
  logic fifo_valid = 1'b0;
  logic fifo_ready;
  logic [31:0] fifo_data = '0;
  logic fifo_last = 1'b0;
  logic [1:0] fifo_nbytes = '0;
  logic [7:0] rx_stat = '0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic hw_en = 1'b0;
  logic [11:0] hw_idx = '0;
  logic [31:0] hw_data = '0;
  logic fill = 1'b1;
  int txn = 0;

  logic [31:0] q_data [0:255];
  logic q_last [0:255];
  logic [1:0] q_nb [0:255];
  logic [7:0] rd_ptr = '0;
  logic [7:0] wr_ptr = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rx_desc_dma u0 (
    .clk(clk), .rst(rst), .desc_base(BASE), .poll(poll),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .fifo_last(fifo_last), .fifo_nbytes(fifo_nbytes), .rx_stat(rx_stat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 4096; i++) mem[i] <= SENT;
    end
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      txn <= txn + 1;
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[13:2]];
    end
    if (hw_en) mem[hw_idx] <= hw_data;
    if (fifo_valid && fifo_ready) rd_ptr <= rd_ptr + 8'd1;
  end

  always @(negedge clk) begin
    fifo_valid  = (rd_ptr != wr_ptr);
    fifo_data   = q_data[rd_ptr];
    fifo_last   = q_last[rd_ptr];
    fifo_nbytes = q_nb[rd_ptr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    hw_en = 1'b1; hw_idx = addr[13:2]; hw_data = data;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  function automatic logic [31:0] w1v(input int b1, input int b2, input bit chn, input bit eor);
    return (32'(b2) << 11) | 32'(b1) | (chn ? 32'h0100_0000 : 32'h0) | (eor ? 32'h0200_0000 : 32'h0);
  endfunction

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    hwr(a, w0); hwr(a + 4, w1); hwr(a + 8, w2); hwr(a + 12, w3);
  endtask

  task automatic push_pkt(input logic [31:0] tag, input int nw, input logic [1:0] nb);
    for (int i = 0; i < nw; i++) begin
      q_data[wr_ptr] = tag + 32'(i);
      q_last[wr_ptr] = (i == nw - 1);
      q_nb[wr_ptr]   = (i == nw - 1) ? nb : 2'd3;
      wr_ptr = wr_ptr + 8'd1;
    end
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 mem_req in reset", {31'd0, mem_req}, 32'd0);
    chk("R10 fifo_ready in reset", {31'd0, fifo_ready}, 32'd0);
  endtask

  task automatic t_own_and_short();
    rx_stat = 8'h3C;
    pulse_poll();
    push_pkt(32'hA100_0000, 5, 2'd1);
    settle();
    chk("R1 single read on unowned", 32'(txn), 32'd1);
    chk("R1 fifo_ready held low", {31'd0, fifo_ready}, 32'd0);
    chk("R1 buffer untouched", mem[32'h1000 >> 2], SENT);
    set_desc(BASE, OWN, w1v(64, 0, 0, 0), 32'h1000, 32'h1800);
    pulse_poll();
    settle();
    for (int i = 0; i < 5; i++)
      chk("R4 short packet data", mem[(32'h1000 >> 2) + i], 32'hA100_0000 + 32'(i));
    chk("R4 no write past packet", mem[32'h1014 >> 2], SENT);
    chk("R5 empty second buffer untouched", mem[32'h1800 >> 2], SENT);
    chk("R7 status single descriptor", mem[BASE >> 2], (32'd18 << 16) | FS | LS | 32'h3C);
    chk("R11 fifo drained", {31'd0, fifo_valid}, 32'd0);
  endtask

  task automatic t_two_buffers();
    int t0;
    rx_stat = 8'h41;
    set_desc(32'h110, OWN, w1v(8, 13, 0, 0), 32'h1100, 32'h1200);
    t0 = txn;
    pulse_poll();
    push_pkt(32'hB200_0000, 4, 2'd3);
    settle();
    chk("R4 buf1 word0", mem[32'h1100 >> 2], 32'hB200_0000);
    chk("R4 buf1 word1", mem[32'h1104 >> 2], 32'hB200_0001);
    chk("R4 buf1 limit", mem[32'h1108 >> 2], SENT);
    chk("R4 buf2 word0", mem[32'h1200 >> 2], 32'hB200_0002);
    chk("R4 buf2 word1", mem[32'h1204 >> 2], 32'hB200_0003);
    chk("R4 buf2 beyond packet", mem[32'h1208 >> 2], SENT);
    chk("R7 status two buffers", mem[32'h110 >> 2], (32'd16 << 16) | FS | LS | 32'h41);
    chk("R9 access count", 32'(txn - t0), 32'd10);
  endtask

  task automatic t_zero_buf1_and_wrap();
    rx_stat = 8'h07;
    set_desc(32'h120, OWN, w1v(0, 16, 0, 1), 32'h1280, 32'h1300);
    pulse_poll();
    push_pkt(32'hC300_0000, 2, 2'd3);
    settle();
    chk("R5 zero-size buf1 skipped", mem[32'h1280 >> 2], SENT);
    chk("R5 data in buf2 word0", mem[32'h1300 >> 2], 32'hC300_0000);
    chk("R5 data in buf2 word1", mem[32'h1304 >> 2], 32'hC300_0001);
    chk("R7 status end-of-ring desc", mem[32'h120 >> 2], (32'd8 << 16) | FS | LS | 32'h07);
    chk("R2 no step past ring end", mem[32'h130 >> 2], SENT);
    rx_stat = 8'h11;
    set_desc(BASE, OWN, w1v(16, 0, 0, 0), 32'h1400, 32'h0);
    pulse_poll();
    push_pkt(32'hD400_0000, 1, 2'd3);
    settle();
    chk("R2 wrapped to base buffer", mem[32'h1400 >> 2], 32'hD400_0000);
    chk("R2 wrapped status", mem[BASE >> 2], (32'd4 << 16) | FS | LS | 32'h11);
  endtask

  task automatic t_chain_span();
    rx_stat = 8'h22;
    set_desc(32'h110, OWN, w1v(8, 8, 1, 0), 32'h1500, 32'h200);
    set_desc(32'h200, OWN, w1v(8, 0, 1, 0), 32'h1600, 32'h300);
    pulse_poll();
    push_pkt(32'hE500_0000, 4, 2'd3);
    settle();
    chk("R3 chain desc A data0", mem[32'h1500 >> 2], 32'hE500_0000);
    chk("R3 chain desc A data1", mem[32'h1504 >> 2], 32'hE500_0001);
    chk("R3 chain desc B data0", mem[32'h1600 >> 2], 32'hE500_0002);
    chk("R3 chain desc B data1", mem[32'h1604 >> 2], 32'hE500_0003);
    chk("R3 buf2 unused in chain", mem[32'h204 >> 2], w1v(8, 0, 1, 0));
    chk("R6 first desc status", mem[32'h110 >> 2], FS);
    chk("R6 last desc status", mem[32'h200 >> 2], (32'd16 << 16) | LS | 32'h22);
  endtask

  task automatic t_overflow();
    rx_stat = 8'h5E;
    set_desc(32'h300, OWN, w1v(8, 0, 0, 0), 32'h1700, 32'h0);
    pulse_poll();
    push_pkt(32'hF600_0000, 5, 2'd0);
    settle();
    chk("R8 data0 kept", mem[32'h1700 >> 2], 32'hF600_0000);
    chk("R8 data1 kept", mem[32'h1704 >> 2], 32'hF600_0001);
    chk("R8 no spill past buffer", mem[32'h1708 >> 2], SENT);
    chk("R8 overflow status", mem[32'h300 >> 2], (32'd17 << 16) | OVF | FS | LS | 32'h5E);
    chk("R8 rest flushed", {31'd0, fifo_valid}, 32'd0);
    chk("R8 unowned desc untouched", mem[32'h310 >> 2], SENT);
    chk("R8 idle after flush", {30'd0, fifo_ready, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    fill = 1'b0;
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_own_and_short();
    t_two_buffers();
    t_zero_buf1_and_wrap();
    t_chain_span();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule